// File: doc/BRIEF.md
# Programmable Prescale Timer with Interval Interrupt

This block is an 8-bit binary up-counter that advances once for every cycle in which an incoming tick qualifier is high. One tap of the counter drives a single-cycle enable pulse for a cascaded prescaler stage. The tap is chosen by a 3-bit divide code. A second tap is chosen on its own by a 3-bit interval code. That second tap sets an interrupt flag, and the flag, gated by an enable bit, forms the interrupt request.

A 16-bit control word holds the divide code, a hold bit, the interval code, the interrupt enable and the interrupt flag. Software writes and reads this word. When the calendar-mode input is high, the divide code is replaced by the /256 ratio. In that mode the local hold bit stops nothing, and a global hold input controls counting instead. A synchronous clear input returns the counter to zero and leaves the control word unchanged.

Top module: `psc_timer`

## Requirements
- R1: After reset the control word reads 0x0100 (hold = 1, every other field 0), `irq_o` is 0, and no divided pulse appears however many ticks arrive.
- R2: Divide code n (bits 13-11) gives one `div_pulse_o` pulse for every 2^(n+1) counted ticks, from /2 (code 0) to /256 (code 7). The pulse comes when counter bit n goes from 1 to 0. It lasts one cycle and is high in the cycle after the tick's clock edge.
- R3: Interval code n (bits 4-2) sets the flag (bit 0) once every 2^(n+1) counted ticks, using the same mapping as the divide code. This tap is independent of the divide tap.
- R4: With hold (bit 8) at 1 and calendar mode off, the counter keeps its value. Clearing hold resumes counting from that value.
- R5: With `cal_mode_i` = 1, the divide code and the hold bit have no effect. The output ratio is /256, and `glob_hold_i` = 1 stops counting without losing the count.
- R6: `irq_o` is 1 exactly when the enable (bit 1) and the flag (bit 0) are both 1.
- R7: Software can write the flag to 0 or 1. If an interval event and a software write of 0 to the flag fall in the same cycle, the flag ends up 1.
- R8: Bits 15-14, 10-9 and 7-5 always read 0, and writes to them are ignored. Writing 0xFFFF reads back as 0x391F.
- R9: `sw_clr_i` sets the counter to 0 at the next edge without changing the control word. It wins over a tick in the same cycle, and it raises neither a pulse nor a flag.
- R10: The counter advances only in cycles where `tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count qualifier; the counter advances once per cycle it is high |
| cal_mode_i | input | 1 | Calendar mode: forces /256 and hands stop control to `glob_hold_i` |
| glob_hold_i | input | 1 | Global stop, active only in calendar mode |
| sw_clr_i | input | 1 | Synchronous counter clear |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 16 | Control word write data |
| rd_data_o | output | 16 | Control word read data |
| div_pulse_o | output | 1 | One-cycle divided enable for a cascaded stage |
| irq_o | output | 1 | Interrupt request |

## Verification
The counter cannot be read directly. A wrong count therefore shows up as a divided pulse or a flag set that comes early or late, and the shift can equal a full period of the selected tap, up to 256 ticks after the fault. The bench counts ticks up to each expected edge and checks that no pulse comes one tick early and that one comes on the exact tick. A corrupted control field shows up at once on the next read of the word and on `irq_o`. The flag collision and clear-versus-tick cases are driven in one chosen cycle, and their result shows one cycle later.

// File: rtl/psc_pkg.sv
package psc_pkg;
    localparam int SEL_W   = 3;
    localparam int CNT_W   = 2 ** SEL_W;
    localparam int REG_W   = 16;

    localparam int DIV_LSB  = 11;
    localparam int HOLD_BIT = 8;
    localparam int IP_LSB   = 2;
    localparam int IE_BIT   = 1;
    localparam int FLAG_BIT = 0;

    localparam logic [REG_W-1:0] RSV_MASK = 16'hC6E0;

    typedef struct packed {
        logic [SEL_W-1:0] div_sel;
        logic             hold;
        logic [SEL_W-1:0] ip_sel;
        logic             ie;
        logic             flag;
    } ctrl_t;
endpackage

// File: rtl/psc_counter.sv
module psc_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             adv_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       adv;

    always_comb begin
        st_d = st_q;
        adv  = tick_i && run_i && !clr_i;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (adv) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign adv_o = adv;

    // R9
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));

    // R4
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i || !run_i) && !clr_i |=> $stable(cnt_o));

    // R10
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run_i && !clr_i) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));
endmodule

// File: rtl/psc_tap_fall.sv
module psc_tap_fall #(
    parameter int CNT_W = 8,
    parameter int SEL_W = 3
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             adv_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             fall_o
);
    logic [CNT_W-1:0] ok;

    for (genvar k = 0; k < CNT_W; k++) begin : g_bit
        assign ok[k] = cnt_i[k] || (SEL_W'(k) > sel_i);
    end

    assign fall_o = adv_i && (&ok);
endmodule

// File: rtl/psc_ctrl_reg.sv
module psc_ctrl_reg
    import psc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             evt_i,
    output ctrl_t            ctrl_o,
    output logic [REG_W-1:0] rd_data_o
);
    ctrl_t ctrl_d, ctrl_q;
    logic  unused_rsv;

    assign unused_rsv = ^(wr_data_i & RSV_MASK);

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en_i) begin
            ctrl_d.div_sel = wr_data_i[DIV_LSB +: SEL_W];
            ctrl_d.hold    = wr_data_i[HOLD_BIT];
            ctrl_d.ip_sel  = wr_data_i[IP_LSB +: SEL_W];
            ctrl_d.ie      = wr_data_i[IE_BIT];
            ctrl_d.flag    = wr_data_i[FLAG_BIT];
        end
        if (evt_i) begin
            ctrl_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q      <= '0;
            ctrl_q.hold <= 1'b1;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        rd_data_o                        = '0;
        rd_data_o[DIV_LSB +: SEL_W]      = ctrl_q.div_sel;
        rd_data_o[HOLD_BIT]              = ctrl_q.hold;
        rd_data_o[IP_LSB +: SEL_W]       = ctrl_q.ip_sel;
        rd_data_o[IE_BIT]                = ctrl_q.ie;
        rd_data_o[FLAG_BIT]              = ctrl_q.flag;
    end

    assign ctrl_o = ctrl_q;

    // R3 R7
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> rd_data_o[FLAG_BIT]);

    // R8
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o & RSV_MASK) == '0);

    // R8
    no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i && !evt_i |=> $stable(rd_data_o));
endmodule

// File: rtl/psc_timer.sv
module psc_timer
    import psc_pkg::*;
#(
    parameter logic [SEL_W-1:0] CAL_SEL = 3'd7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cal_mode_i,
    input  logic             glob_hold_i,
    input  logic             sw_clr_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             div_pulse_o,
    output logic             irq_o
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] cnt;
    logic             adv;
    logic             run;
    logic [SEL_W-1:0] div_sel_eff;
    logic             div_fall;
    logic             ip_fall;

    typedef struct packed {
        logic pulse;
    } out_state_t;

    out_state_t out_d, out_q;

    always_comb begin
        run         = cal_mode_i ? !glob_hold_i : !ctrl.hold;
        div_sel_eff = cal_mode_i ? CAL_SEL : ctrl.div_sel;
        out_d       = out_q;
        out_d.pulse = div_fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    psc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .run_i  (run),
        .clr_i  (sw_clr_i),
        .cnt_o  (cnt),
        .adv_o  (adv)
    );

    psc_tap_fall #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_div_tap (
        .cnt_i  (cnt),
        .adv_i  (adv),
        .sel_i  (div_sel_eff),
        .fall_o (div_fall)
    );

    psc_tap_fall #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_ip_tap (
        .cnt_i  (cnt),
        .adv_i  (adv),
        .sel_i  (ctrl.ip_sel),
        .fall_o (ip_fall)
    );

    psc_ctrl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .evt_i     (ip_fall),
        .ctrl_o    (ctrl),
        .rd_data_o (rd_data_o)
    );

    assign div_pulse_o = out_q.pulse;
    assign irq_o       = ctrl.ie && ctrl.flag;

    // R2
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse_o |=> !div_pulse_o);

    // R5
    glob_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_mode_i && glob_hold_i && !sw_clr_i |=> $stable(cnt));

    // R9
    clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr_i |=> !div_pulse_o);

    // R2
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse_o |-> $past(tick_i));
endmodule

// File: tb/psc_timer_tb.sv
module psc_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        cal_mode_i = 1'b0;
    logic        glob_hold_i = 1'b0;
    logic        sw_clr_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] rd_data_o;
    logic        div_pulse_o;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    psc_timer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .cal_mode_i  (cal_mode_i),
        .glob_hold_i (glob_hold_i),
        .sw_clr_i    (sw_clr_i),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .rd_data_o   (rd_data_o),
        .div_pulse_o (div_pulse_o),
        .irq_o       (irq_o)
    );

    function automatic logic [15:0] mk(int dv, bit hd, int ip, bit ie, bit fl);
        logic [15:0] w;
        w = '0;
        w[13:11] = 3'(dv);
        w[8]     = hd;
        w[4:2]   = 3'(ip);
        w[1]     = ie;
        w[0]     = fl;
        return w;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] d);
        @(negedge clk);
        wr_en_i = 1'b1;
        wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic clr_cnt();
        @(negedge clk);
        sw_clr_i = 1'b1;
        @(negedge clk);
        sw_clr_i = 1'b0;
    endtask

    // Tick on n consecutive cycles, then count pulses seen
    task automatic ticks(int n);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pulses += int'(div_pulse_o);
            tick_i = 1'b1;
        end
        @(negedge clk);
        tick_i = 1'b0;
        pulses += int'(div_pulse_o);
    endtask

    task automatic t_reset();
        chk(rd_data_o == 16'h0100, "R1 reset word", rd_data_o, 16'h0100);
        chk(irq_o == 1'b0, "R1 reset irq", irq_o, 0);
        ticks(20);
        chk(pulses == 0, "R1 held after reset", pulses, 0);
    endtask

    task automatic t_divide();
        for (int n = 0; n < 8; n++) begin
            int p;
            p = 1 << (n + 1);
            wr(mk(n, 0, 7, 0, 0));
            clr_cnt();
            ticks(p - 1);
            chk(pulses == 0, $sformatf("R2 early n=%0d", n), pulses, 0);
            ticks(1);
            chk(pulses == 1, $sformatf("R2 edge n=%0d", n), pulses, 1);
            ticks(p);
            chk(pulses == 1, $sformatf("R2 period n=%0d", n), pulses, 1);
        end
    endtask

    task automatic t_interval();
        wr(mk(0, 0, 2, 0, 0));
        clr_cnt();
        ticks(7);
        chk(rd_data_o[0] == 1'b0, "R3 flag early", rd_data_o[0], 0);
        chk(pulses == 3, "R3 div tap independent", pulses, 3);
        ticks(1);
        chk(rd_data_o[0] == 1'b1, "R3 flag at /8", rd_data_o[0], 1);
        chk(irq_o == 1'b0, "R6 irq masked", irq_o, 0);
        wr(mk(0, 0, 2, 1, 1));
        chk(irq_o == 1'b1, "R6 irq raised", irq_o, 1);
        wr(mk(0, 0, 2, 1, 0));
        chk(irq_o == 1'b0, "R6 irq after flag clear", irq_o, 0);
        wr(mk(0, 1, 2, 0, 1));
        chk(rd_data_o[0] == 1'b1, "R7 software set", rd_data_o[0], 1);
    endtask

    task automatic t_hold();
        wr(mk(2, 0, 7, 0, 0));
        clr_cnt();
        ticks(5);
        chk(pulses == 0, "R4 before hold", pulses, 0);
        wr(mk(2, 1, 7, 0, 0));
        ticks(10);
        chk(pulses == 0, "R4 held", pulses, 0);
        wr(mk(2, 0, 7, 0, 0));
        repeat (20) @(negedge clk);
        chk(div_pulse_o == 1'b0, "R10 idle no tick", div_pulse_o, 0);
        ticks(2);
        chk(pulses == 0, "R4 resume early", pulses, 0);
        ticks(1);
        chk(pulses == 1, "R4 resume from kept value", pulses, 1);
    endtask

    task automatic t_cal();
        wr(mk(0, 1, 7, 0, 0));
        cal_mode_i = 1'b1;
        clr_cnt();
        ticks(255);
        chk(pulses == 0, "R5 cal early", pulses, 0);
        ticks(1);
        chk(pulses == 1, "R5 cal /256", pulses, 1);
        ticks(100);
        glob_hold_i = 1'b1;
        ticks(300);
        chk(pulses == 0, "R5 global hold", pulses, 0);
        glob_hold_i = 1'b0;
        ticks(155);
        chk(pulses == 0, "R5 resume early", pulses, 0);
        ticks(1);
        chk(pulses == 1, "R5 resume edge", pulses, 1);
        cal_mode_i = 1'b0;
    endtask

    task automatic t_collide();
        wr(mk(7, 0, 0, 0, 0));
        clr_cnt();
        ticks(1);
        chk(rd_data_o[0] == 1'b0, "R7 no event yet", rd_data_o[0], 0);
        @(negedge clk);
        tick_i = 1'b1;
        wr_en_i = 1'b1;
        wr_data_i = mk(7, 0, 0, 0, 0);
        @(negedge clk);
        tick_i = 1'b0;
        wr_en_i = 1'b0;
        chk(rd_data_o[0] == 1'b1, "R7 hardware set wins", rd_data_o[0], 1);
    endtask

    task automatic t_reserved();
        wr(16'hFFFF);
        chk(rd_data_o == 16'h391F, "R8 all ones", rd_data_o, 16'h391F);
        wr(16'hC6E0);
        chk(rd_data_o == 16'h0000, "R8 reserved only", rd_data_o, 0);
    endtask

    task automatic t_clear();
        wr(mk(3, 0, 7, 1, 0));
        ticks(9);
        clr_cnt();
        chk(rd_data_o == mk(3, 0, 7, 1, 0), "R9 fields kept", rd_data_o, mk(3, 0, 7, 1, 0));
        ticks(5);
        @(negedge clk);
        tick_i = 1'b1;
        sw_clr_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        sw_clr_i = 1'b0;
        chk(div_pulse_o == 1'b0, "R9 clear quiet", div_pulse_o, 0);
        ticks(15);
        chk(pulses == 0, "R9 clear beats tick", pulses, 0);
        ticks(1);
        chk(pulses == 1, "R9 restart from zero", pulses, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_divide();
        t_interval();
        t_hold();
        t_cal();
        t_collide();
        t_reserved();
        t_clear();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule